// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block holds the power state of a processor core and decides which low-power depth the core enters when it executes its sleep instruction. The core pulses a sleep strobe. The controller then reads one selector bit from each of two standby control values and chooses the depth. The primary value outranks the secondary one. The controller stays in the chosen depth until an interrupt is pending or reset is applied, and then it returns to the running state.

The controller drives three enables from the state it holds. The first stalls the core. The second gates the clock of the timer, serial and performance-counter peripherals, and is low only in the deepest depth. The third halts the DMA engine in the two deeper depths. Clock generation and the peripherals themselves sit outside this block. Control-value width, selector bit position and an optional output register stage are parameters.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the state output is 0 (running), core_halt is 0, periph_clk_en is 1 and dma_halt is 0.
- R2: A sleep strobe in the running state with bit SEL_BIT (default 7) of stby_ctl set moves the state to 3 (standby) at the next clock edge, whatever stby_ctl2 holds.
- R3: A sleep strobe in the running state with stby_ctl bit SEL_BIT clear and stby_ctl2 bit SEL_BIT set moves the state to 2 (deep sleep) at the next edge.
- R4: A sleep strobe in the running state with both selector bits clear moves the state to 1 (light sleep). Every other bit of both control values is ignored.
- R5: A pending interrupt in any of states 1, 2 or 3 returns the state to 0 at the next edge.
- R6: A sleep strobe in the running state while irq_pend is high is ignored, and the state stays 0.
- R7: core_halt is high in every state except 0.
- R8: periph_clk_en is low in state 3 only, so the timer and serial peripherals keep their clock in states 1 and 2.
- R9: dma_halt is high in states 2 and 3 and low in states 0 and 1.
- R10: In a low-power state with irq_pend low, the state holds, and a further sleep strobe has no effect.
- R11: Asserting rst_n low returns the state to 0 at once, from any state and without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sleep_req | input | 1 | One-cycle strobe from the core's sleep instruction |
| stby_ctl | input | CTL_W | Primary standby control value; bit SEL_BIT requests standby |
| stby_ctl2 | input | CTL_W | Secondary standby control value; bit SEL_BIT requests deep sleep |
| irq_pend | input | 1 | An interrupt is pending |
| pstate | output | 2 | Power state: 0 running, 1 light sleep, 2 deep sleep, 3 standby |
| core_halt | output | 1 | Stalls the core |
| periph_clk_en | output | 1 | Clock enable for the timer, serial and performance-counter peripherals |
| dma_halt | output | 1 | Halts the DMA engine |

## Verification
With the default OUT_REG=0, a state change caused by sleep_req or irq_pend shows on pstate and on all three enables one clock edge after the edge that samples the stimulus. Reset acts at once, without an edge. The bench drives every input on the falling edge and steps one rising edge. It then reads the outputs on the following falling edge, so each check sees exactly the first cycle in which the new value is due. For reset, the bench reads a nanosecond after rst_n falls, in the middle of a clock phase, to show that no edge was needed.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
   typedef enum logic [1:0] {
      PM_RUN  = 2'd0,
      PM_NAP  = 2'd1,
      PM_DEEP = 2'd2,
      PM_STBY = 2'd3
   } pm_state_e;
endpackage

// File: rtl/pm_depth_sel.sv
module pm_depth_sel
   import pwr_mode_pkg::*;
#(
   parameter int CTL_W   = 8,
   parameter int SEL_BIT = 7
) (
   input  logic [CTL_W-1:0] ctl_pri,
   input  logic [CTL_W-1:0] ctl_sec,
   output pm_state_e        target
);
   initial begin
      assert (SEL_BIT >= 0 && SEL_BIT < CTL_W)
         else $error("pm_depth_sel: SEL_BIT outside control value");
   end

   // Only the selector bits take part in the choice; the rest are ignored.
   logic unused_ctl_bits;
   assign unused_ctl_bits = ^{ctl_pri, ctl_sec};

   // The primary selector outranks the secondary one.
   always_comb begin
      if (ctl_pri[SEL_BIT])      target = PM_STBY;
      else if (ctl_sec[SEL_BIT]) target = PM_DEEP;
      else                       target = PM_NAP;
   end
endmodule

// File: rtl/pm_state_reg.sv
module pm_state_reg
   import pwr_mode_pkg::*;
#(
   parameter int CTL_W   = 8,
   parameter int SEL_BIT = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_req,
   input  logic             irq_pend,
   input  logic [CTL_W-1:0] ctl_pri,
   input  logic [CTL_W-1:0] ctl_sec,
   input  pm_state_e        target,
   output pm_state_e        state
);
   pm_state_e state_nx;

   always_comb begin
      state_nx = state;
      if (state == PM_RUN) begin
         // A strobe that collides with a pending interrupt is dropped.
         if (sleep_req && !irq_pend) state_nx = target;
      end else if (irq_pend) begin
         state_nx = PM_RUN;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= PM_RUN;
      else        state <= state_nx;
   end

   p_stby_pick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_RUN && sleep_req && !irq_pend && ctl_pri[SEL_BIT]) |=> state == PM_STBY);
   p_deep_pick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_RUN && sleep_req && !irq_pend && !ctl_pri[SEL_BIT] && ctl_sec[SEL_BIT])
      |=> state == PM_DEEP);
   p_nap_pick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_RUN && sleep_req && !irq_pend && !ctl_pri[SEL_BIT] && !ctl_sec[SEL_BIT])
      |=> state == PM_NAP);
   p_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state != PM_RUN && irq_pend) |=> state == PM_RUN);
   p_collide_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_RUN && irq_pend) |=> state == PM_RUN);
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state != PM_RUN && !irq_pend) |=> $stable(state));
endmodule

// File: rtl/pm_out_dec.sv
module pm_out_dec
   import pwr_mode_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  pm_state_e state,
   output logic      core_halt,
   output logic      periph_clk_en,
   output logic      dma_halt
);
   logic halt_c, clk_en_c, dma_c;

   always_comb begin
      halt_c   = (state != PM_RUN);
      clk_en_c = (state != PM_STBY);
      dma_c    = (state == PM_DEEP) || (state == PM_STBY);
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               core_halt     <= 1'b0;
               periph_clk_en <= 1'b1;
               dma_halt      <= 1'b0;
            end else begin
               core_halt     <= halt_c;
               periph_clk_en <= clk_en_c;
               dma_halt      <= dma_c;
            end
         end
      end else begin : g_comb
         assign core_halt     = halt_c;
         assign periph_clk_en = clk_en_c;
         assign dma_halt      = dma_c;
      end
   endgenerate
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pwr_mode_pkg::*;
#(
   parameter int CTL_W   = 8,
   parameter int SEL_BIT = 7,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_req,
   input  logic [CTL_W-1:0] stby_ctl,
   input  logic [CTL_W-1:0] stby_ctl2,
   input  logic             irq_pend,
   output logic [1:0]       pstate,
   output logic             core_halt,
   output logic             periph_clk_en,
   output logic             dma_halt
);
   pm_state_e target, state;

   pm_depth_sel #(.CTL_W(CTL_W), .SEL_BIT(SEL_BIT)) u_sel (
      .ctl_pri (stby_ctl),
      .ctl_sec (stby_ctl2),
      .target  (target)
   );

   pm_state_reg #(.CTL_W(CTL_W), .SEL_BIT(SEL_BIT)) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep_req (sleep_req),
      .irq_pend  (irq_pend),
      .ctl_pri   (stby_ctl),
      .ctl_sec   (stby_ctl2),
      .target    (target),
      .state     (state)
   );

   pm_out_dec #(.OUT_REG(OUT_REG)) u_dec (
      .clk           (clk),
      .rst_n         (rst_n),
      .state         (state),
      .core_halt     (core_halt),
      .periph_clk_en (periph_clk_en),
      .dma_halt      (dma_halt)
   );

   assign pstate = state;

   // Enables are nested: a stopped peripheral clock implies a DMA halt,
   // and any halt implies the core is stalled.
   p_gate_nest_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !periph_clk_en |-> (dma_halt && core_halt));
   p_dma_nest_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dma_halt |-> core_halt);
   p_run_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (OUT_REG == 1'b0 && pstate == 2'd0) |-> (!core_halt && periph_clk_en && !dma_halt));
endmodule

// File: tb/tb_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sleep_req = 1'b0;
   logic [7:0] stby_ctl = '0;
   logic [7:0] stby_ctl2 = '0;
   logic       irq_pend = 1'b0;
   logic [1:0] pstate;
   logic       core_halt, periph_clk_en, dma_halt;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pwr_mode_ctrl dut (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
      .stby_ctl(stby_ctl), .stby_ctl2(stby_ctl2), .irq_pend(irq_pend),
      .pstate(pstate), .core_halt(core_halt),
      .periph_clk_en(periph_clk_en), .dma_halt(dma_halt)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Expected enables for a state, taken from R7, R8 and R9.
   task automatic chk_outs(input int st);
      chk("R7 core_halt", core_halt, st != 0);
      chk("R8 periph_clk_en", periph_clk_en, st != 3);
      chk("R9 dma_halt", dma_halt, st >= 2);
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic strobe(input logic [7:0] a, input logic [7:0] b, input logic irq);
      stby_ctl = a; stby_ctl2 = b; irq_pend = irq; sleep_req = 1'b1;
      tick();
      sleep_req = 1'b0; irq_pend = 1'b0;
   endtask

   task automatic wake();
      irq_pend = 1'b1;
      tick();
      irq_pend = 1'b0;
      chk("R5 wake", pstate, 0);
      chk_outs(0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      tick();
      chk("R1 state", pstate, 0);
      chk("R1 core_halt", core_halt, 0);
      chk("R1 periph_clk_en", periph_clk_en, 1);
      chk("R1 dma_halt", dma_halt, 0);
   endtask

   task automatic t_standby();
      strobe(8'h80, 8'h80, 1'b0);
      chk("R2 standby", pstate, 3);
      chk_outs(3);
      tick();
      chk("R10 hold standby", pstate, 3);
      wake();
   endtask

   task automatic t_deep();
      strobe(8'h7F, 8'h80, 1'b0);
      chk("R3 deep", pstate, 2);
      chk_outs(2);
      wake();
   endtask

   task automatic t_nap();
      strobe(8'h7F, 8'h7F, 1'b0);
      chk("R4 nap other bits ignored", pstate, 1);
      chk_outs(1);
      // R10: a further strobe asking for standby is ignored in a sleep state.
      strobe(8'h80, 8'h00, 1'b0);
      chk("R10 strobe ignored", pstate, 1);
      chk_outs(1);
      wake();
   endtask

   task automatic t_collide();
      strobe(8'h80, 8'h00, 1'b1);
      chk("R6 collide", pstate, 0);
      chk_outs(0);
      tick();
      chk("R6 still running", pstate, 0);
   endtask

   task automatic t_async_reset();
      strobe(8'h80, 8'h00, 1'b0);
      chk("R11 pre standby", pstate, 3);
      #2 rst_n = 1'b0;
      #1;
      chk("R11 async state", pstate, 0);
      chk("R11 async clk en", periph_clk_en, 1);
      @(negedge clk);
      rst_n = 1'b1;
      tick();
      chk("R11 after release", pstate, 0);
   endtask

   initial begin
      t_reset();
      t_standby();
      t_deep();
      t_nap();
      t_collide();
      t_async_reset();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule